// File: doc/BRIEF.md
# Cache Maintenance Command Engine

This block holds the tag and data storage of a two-way set-associative data cache (64 sets of 64-byte lines by default) and carries out maintenance commands on it. A command is a 5-bit operation code plus a 32-bit effective address. Hit-class commands first compare the address against both ways of the addressed set and act only on the way that matches. Index-class commands name the set from the address and the way from address bit 0, and act whether or not the line matches anything.

Depending on the operation, the engine clears selected tag flag bits, zeroes a line, or first pushes a whole line out on a single-beat write-back port with a valid/ready handshake. A 32-bit diagnostic register can be loaded from software. Commands can copy a tag or data word into that register, or copy the register into a tag or data word. `cmdDone` pulses once when each command completes. A new command is taken only while `cmdReady` is high.

Tag word layout: bits [31:12] hold the line's page number. Bit 6 is dirty, bit 5 is valid, bit 4 is a replacement flag, and bits [3:0] are general flags.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset `cmdReady` is 1, `cmdDone` and `wbValid` are 0, the diagnostic register reads 0, and every tag word is 0.
- R2: A command is taken on a clock edge where `cmdValid` and `cmdReady` are both 1. `cmdReady` is then 0 until the command ends. `cmdDone` is high for exactly one cycle, with `cmdReady` high in that same cycle. A command without write-back raises `cmdDone` after the second clock edge following acceptance.
- R3: Opcode 0x10 copies the tag word of set addr[11:6], way addr[0], into the diagnostic register. Opcode 0x12 writes the diagnostic register into that tag word.
- R4: Opcode 0x11 loads data word addr[5:2] of the line at set addr[11:6], way addr[0], into the diagnostic register. Opcode 0x13 stores the diagnostic register there. Address bits [1:0] do not affect which word is selected.
- R5: When `diagWrEn` is 1 and no command is writing the diagnostic register, `diagWrData` is loaded into it. `diagRdData` always shows its contents.
- R6: For hit-class opcodes (0x1A, 0x18, 0x1C), a way hits when its valid bit is 1 and its tag bits [31:12] equal addr[31:12]. Way 0 wins when both ways hit. On a miss the command completes with no write-back and no change to any tag.
- R7: Opcode 0x1A clears tag bits 6, 5 and 3:0 (mask 0x6F) of the hit way and zeroes all data words of that line, with no write-back.
- R8: Opcode 0x18 writes the hit line back, because its valid bit is set, and then clears mask 0x6F.
- R9: Opcode 0x1C writes the hit line back and then clears only the dirty bit (bit 6).
- R10: Opcode 0x16 clears mask 0x6F of the indexed way, with no write-back.
- R11: Opcode 0x14 writes the indexed line back when tag bit 5 or bit 6 is set, then clears mask 0x6F. The write-back address is the stored tag's page with set addr[11:6] and byte offset 0.
- R12: The write-back address is {tag[31:12], set, 6'b0}. `wbData` carries data word k at bits [32k+31:32k]. Both stay stable while `wbValid` is high and `wbReady` is low. `cmdDone` rises on the edge after the one where `wbValid` and `wbReady` are both high.
- R13: Any other opcode completes like an index command without write-back, and changes neither tags, data nor the diagnostic register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 5 | Operation code |
| cmdAddr | input | 32 | Effective address |
| cmdReady | output | 1 | Engine idle, command may be taken |
| cmdDone | output | 1 | One-cycle completion pulse |
| diagWrEn | input | 1 | Software load of diagnostic register |
| diagWrData | input | 32 | Value for software load |
| diagRdData | output | 32 | Diagnostic register contents |
| wbValid | output | 1 | Line write-back request |
| wbAddr | output | 32 | Line write-back address |
| wbData | output | 512 | Line write-back data |
| wbReady | input | 1 | Memory accepts the write-back |

## Verification
The hit-class commands are tried in several set states:
- A set where only way 1 matches shows that the hit way is selected, rather than a fixed way.
- A set where both ways carry the same page shows that way 0 wins.
- A matching page with the valid bit clear shows that a dirty but invalid line counts as a miss.

For the index write-back, the command address carries a page different from the stored tag. This tells apart a write-back addressed from the tag and one addressed from the command. Write-back acceptance is delayed by different amounts, which checks that the port holds steady and that completion follows the handshake. Unknown opcodes and a word address with nonzero low bits check that nothing leaks from ignored inputs.

// File: rtl/cme_pkg.sv
package cme_pkg;

  typedef enum logic [4:0] {
    OP_TAG_RD    = 5'h10,
    OP_DATA_RD   = 5'h11,
    OP_TAG_WR    = 5'h12,
    OP_DATA_WR   = 5'h13,
    OP_IDX_WBINV = 5'h14,
    OP_IDX_INV   = 5'h16,
    OP_HIT_WBINV = 5'h18,
    OP_HIT_INV   = 5'h1A,
    OP_HIT_WB    = 5'h1C
  } cmeOp_e;

  localparam int TAG_W     = 32;
  localparam int DIRTY_BIT = 6;
  localparam int VALID_BIT = 5;
  localparam logic [TAG_W-1:0] CLR_ALL_MASK   = 32'h0000_006F;
  localparam logic [TAG_W-1:0] CLR_DIRTY_MASK = 32'h0000_0040;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic useHit;
    logic tagClrAll;
    logic tagClrDirty;
    logic zeroLine;
    logic tagToDiag;
    logic diagToTag;
    logic dataToDiag;
    logic diagToData;
  } cmeStrobe_t;

endpackage

// File: rtl/cme_ctrl.sv
module cme_ctrl
  import cme_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [4:0] cmdOp,
  input  logic       hit,
  input  logic       wbCand,
  input  logic       wbReady,
  output cmeStrobe_t stb,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic       wbValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WBACK} state_e;

  state_e     state;
  logic [4:0] opReg;
  logic       isHitOp;
  logic       isWbOp;
  logic       proceed;
  logic       needWb;
  logic       applyNow;

  always_comb begin
    isHitOp = (opReg == OP_HIT_INV) || (opReg == OP_HIT_WBINV) || (opReg == OP_HIT_WB);
    isWbOp  = (opReg == OP_HIT_WBINV) || (opReg == OP_HIT_WB) || (opReg == OP_IDX_WBINV);
    proceed = isHitOp ? hit : 1'b1;
    needWb  = proceed && isWbOp && wbCand;
    applyNow = ((state == ST_LOOK) && !needWb) || ((state == ST_WBACK) && wbReady);
  end

  always_comb begin
    stb         = '0;
    stb.capture = (state == ST_IDLE) && cmdValid;
    stb.useHit  = isHitOp;
    if (applyNow && proceed) begin
      case (opReg)
        OP_TAG_RD:    stb.tagToDiag   = 1'b1;
        OP_DATA_RD:   stb.dataToDiag  = 1'b1;
        OP_TAG_WR:    stb.diagToTag   = 1'b1;
        OP_DATA_WR:   stb.diagToData  = 1'b1;
        OP_IDX_WBINV: stb.tagClrAll   = 1'b1;
        OP_IDX_INV:   stb.tagClrAll   = 1'b1;
        OP_HIT_WBINV: stb.tagClrAll   = 1'b1;
        OP_HIT_WB:    stb.tagClrDirty = 1'b1;
        OP_HIT_INV: begin
          stb.tagClrAll = 1'b1;
          stb.zeroLine  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= '0;
      cmdDone <= 1'b0;
    end else begin
      cmdDone <= 1'b0;
      case (state)
        ST_IDLE: if (cmdValid) begin
          opReg <= cmdOp;
          state <= ST_LOOK;
        end
        ST_LOOK: if (needWb) begin
          state <= ST_WBACK;
        end else begin
          state   <= ST_IDLE;
          cmdDone <= 1'b1;
        end
        ST_WBACK: if (wbReady) begin
          state   <= ST_IDLE;
          cmdDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdReady = (state == ST_IDLE);
  assign wbValid  = (state == ST_WBACK);

endmodule

// File: rtl/cme_datapath.sv
module cme_datapath
  import cme_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TAG_W-1:0]          cmdAddr,
  input  cmeStrobe_t                stb,
  input  logic                      diagWrEn,
  input  logic [TAG_W-1:0]          diagWrData,
  output logic [TAG_W-1:0]          diagRdData,
  output logic                      hit,
  output logic                      wbCand,
  output logic [TAG_W-1:0]          wbAddr,
  output logic [LINE_BYTES*8-1:0]   wbData
);

  localparam int WAYS      = 2;
  localparam int OFF_BITS  = $clog2(LINE_BYTES);
  localparam int SET_BITS  = $clog2(SETS);
  localparam int PAGE_LSB  = OFF_BITS + SET_BITS;
  localparam int WORDS     = LINE_BYTES / 4;
  localparam int WORD_BITS = $clog2(WORDS);
  localparam int ENT_BITS  = SET_BITS + 1;
  localparam int ENTRIES   = SETS * WAYS;
  localparam int DAT_BITS  = ENT_BITS + WORD_BITS;
  localparam int DAT_WORDS = ENTRIES * WORDS;

  logic [TAG_W-1:0]    tagMem  [ENTRIES];
  logic [TAG_W-1:0]    dataMem [DAT_WORDS];
  logic [TAG_W-1:0]    addrReg;
  logic [TAG_W-1:0]    diagReg;
  logic [SET_BITS-1:0] setIdx;
  logic [WORD_BITS-1:0] wordIdx;
  logic [WAYS-1:0]     hitW;
  logic                hitWay;
  logic                selWay;
  logic [ENT_BITS-1:0] selEnt;
  logic [TAG_W-1:0]    selTag;

  assign setIdx  = addrReg[PAGE_LSB-1:OFF_BITS];
  assign wordIdx = addrReg[OFF_BITS-1:2];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] wayTag;
    assign wayTag  = tagMem[{setIdx, 1'(w)}];
    assign hitW[w] = wayTag[VALID_BIT] &&
                     (wayTag[TAG_W-1:PAGE_LSB] == addrReg[TAG_W-1:PAGE_LSB]);
  end

  assign hit    = |hitW;
  assign hitWay = !hitW[0];
  assign selWay = stb.useHit ? hitWay : addrReg[0];
  assign selEnt = {setIdx, selWay};
  assign selTag = tagMem[selEnt];
  assign wbCand = selTag[VALID_BIT] || selTag[DIRTY_BIT];
  assign wbAddr = {selTag[TAG_W-1:PAGE_LSB], setIdx, {OFF_BITS{1'b0}}};

  for (genvar k = 0; k < WORDS; k++) begin : g_wbword
    assign wbData[k*32 +: 32] = dataMem[{selEnt, WORD_BITS'(k)}];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (stb.capture) begin
      addrReg <= cmdAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) tagMem[e] <= '0;
    end else if (stb.diagToTag) begin
      tagMem[selEnt] <= diagReg;
    end else if (stb.tagClrAll) begin
      tagMem[selEnt] <= selTag & ~CLR_ALL_MASK;
    end else if (stb.tagClrDirty) begin
      tagMem[selEnt] <= selTag & ~CLR_DIRTY_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.zeroLine) begin
      for (int k = 0; k < WORDS; k++) dataMem[{selEnt, WORD_BITS'(k)}] <= '0;
    end else if (stb.diagToData) begin
      dataMem[{selEnt, wordIdx}] <= diagReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      diagReg <= '0;
    end else if (stb.tagToDiag) begin
      diagReg <= selTag;
    end else if (stb.dataToDiag) begin
      diagReg <= dataMem[{selEnt, wordIdx}];
    end else if (diagWrEn) begin
      diagReg <= diagWrData;
    end
  end

  assign diagRdData = diagReg;

  logic unusedDat;
  assign unusedDat = ^{DAT_BITS'(0)};

endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import cme_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [4:0]              cmdOp,
  input  logic [31:0]             cmdAddr,
  output logic                    cmdReady,
  output logic                    cmdDone,
  input  logic                    diagWrEn,
  input  logic [31:0]             diagWrData,
  output logic [31:0]             diagRdData,
  output logic                    wbValid,
  output logic [31:0]             wbAddr,
  output logic [LINE_BYTES*8-1:0] wbData,
  input  logic                    wbReady
);

  localparam int LINE_BITS = LINE_BYTES * 8;

  cmeStrobe_t stb;
  logic       hit;
  logic       wbCand;

  cme_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .hit      (hit),
    .wbCand   (wbCand),
    .wbReady  (wbReady),
    .stb      (stb),
    .cmdReady (cmdReady),
    .cmdDone  (cmdDone),
    .wbValid  (wbValid)
  );

  cme_datapath #(
    .SETS       (SETS),
    .LINE_BYTES (LINE_BYTES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmdAddr    (cmdAddr),
    .stb        (stb),
    .diagWrEn   (diagWrEn),
    .diagWrData (diagWrData),
    .diagRdData (diagRdData),
    .hit        (hit),
    .wbCand     (wbCand),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );

endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
  parameter int LINE_BITS = 512
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic                 cmdReady,
  input logic                 cmdDone,
  input logic                 wbValid,
  input logic                 wbReady,
  input logic [31:0]          wbAddr,
  input logic [LINE_BITS-1:0] wbData
);

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  // R2: an accepted command makes the engine busy
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R2: completion is reported while idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> cmdReady);

  // R12: write-back request held steady until taken
  p_wb_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

  // R12: completion follows the write-back handshake
  p_wb_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbReady) |=> cmdDone);

  // R12: no write-back request while idle
  p_wb_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !wbValid);

endmodule

bind cache_maint_engine cme_checker #(.LINE_BITS(LINE_BITS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdDone  (cmdDone),
  .wbValid  (wbValid),
  .wbReady  (wbReady),
  .wbAddr   (wbAddr),
  .wbData   (wbData)
);

// File: tb/cache_maint_engine_tb_top.sv
module cache_maint_engine_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [4:0]   cmdOp = '0;
  logic [31:0]  cmdAddr = '0;
  logic         cmdReady;
  logic         cmdDone;
  logic         diagWrEn = 1'b0;
  logic [31:0]  diagWrData = '0;
  logic [31:0]  diagRdData;
  logic         wbValid;
  logic [31:0]  wbAddr;
  logic [511:0] wbData;
  logic         wbReady = 1'b0;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  cache_maint_engine dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .diagWrEn(diagWrEn), .diagWrData(diagWrData),
    .diagRdData(diagRdData), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .wbReady(wbReady)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] idxAddr(input int set, input int word, input int way);
    return (32'(set) << 6) | (32'(word) << 2) | 32'(way);
  endfunction

  function automatic logic [31:0] hitAddr(input logic [19:0] page, input int set, input logic [5:0] off);
    return {page, 6'(set), off};
  endfunction

  task automatic runCmd(input logic [4:0] op, input logic [31:0] addr, input int wbDelay,
                        output bit sawWb, output logic [31:0] wA, output logic [511:0] wD,
                        output int cyc);
    int waitCnt = 0;
    bit first = 1;
    logic [31:0]  pa = '0;
    logic [511:0] pd = '0;
    sawWb = 0; wA = '0; wD = '0; cyc = 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr;
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 1;
    while (!cmdDone && cyc < 100) begin
      if (wbValid) begin
        if (!first)
          check((wbAddr === pa) && (wbData === pd), "R12 wb stable", wbAddr, pa);
        check(!cmdReady, "R2 busy during wb", 32'(cmdReady), 32'd0);
        first = 0; pa = wbAddr; pd = wbData;
        sawWb = 1; wA = wbAddr; wD = wbData;
        wbReady = (waitCnt >= wbDelay);
        waitCnt++;
      end else begin
        wbReady = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    wbReady = 1'b0;
    check(cmdDone && cmdReady, "R2 done while ready", {cmdDone, cmdReady}, 32'd3);
    @(negedge clk);
    check(!cmdDone, "R2 done one cycle", 32'(cmdDone), 32'd0);
  endtask

  task automatic diagWr(input logic [31:0] v);
    @(negedge clk);
    diagWrEn = 1'b1; diagWrData = v;
    @(negedge clk);
    diagWrEn = 1'b0;
  endtask

  task automatic simpleCmd(input logic [4:0] op, input logic [31:0] addr);
    bit s; logic [31:0] a; logic [511:0] d; int c;
    runCmd(op, addr, 0, s, a, d, c);
  endtask

  task automatic setTag(input int set, input int way, input logic [31:0] v);
    diagWr(v);
    simpleCmd(5'h12, idxAddr(set, 0, way));
  endtask

  task automatic getTag(input int set, input int way, output logic [31:0] v);
    simpleCmd(5'h10, idxAddr(set, 0, way));
    v = diagRdData;
  endtask

  task automatic setWord(input int set, input int way, input int word, input logic [31:0] v);
    diagWr(v);
    simpleCmd(5'h13, idxAddr(set, word, way));
  endtask

  task automatic getWord(input int set, input int way, input int word, output logic [31:0] v);
    simpleCmd(5'h11, idxAddr(set, word, way));
    v = diagRdData;
  endtask

  task automatic tReset();
    logic [31:0] v;
    check(cmdReady === 1'b1, "R1 ready", 32'(cmdReady), 32'd1);
    check(cmdDone === 1'b0 && wbValid === 1'b0, "R1 done/wb low", {cmdDone, wbValid}, 32'd0);
    check(diagRdData === 32'd0, "R1 diag", diagRdData, 32'd0);
    getTag(5, 1, v);
    check(v === 32'd0, "R1 tag zero", v, 32'd0);
  endtask

  task automatic tDiagReg();
    diagWr(32'hC0DE_1234);
    @(negedge clk);
    check(diagRdData === 32'hC0DE_1234, "R5 diag write", diagRdData, 32'hC0DE_1234);
  endtask

  task automatic tTagDiag();
    logic [31:0] v;
    setTag(3, 1, 32'h1234_507F);
    getTag(3, 1, v);
    check(v === 32'h1234_507F, "R3 tag way1", v, 32'h1234_507F);
    getTag(3, 0, v);
    check(v === 32'd0, "R3 tag way0 untouched", v, 32'd0);
  endtask

  task automatic tDataDiag();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    diagWr(32'hDEAD_BEEF);
    runCmd(5'h13, idxAddr(5, 9, 0) | 32'h2, 0, s, a, d, c);
    check(c == 2, "R2 cycles", 32'(c), 32'd2);
    setWord(5, 0, 8, 32'h0123_4567);
    getWord(5, 0, 9, v);
    check(v === 32'hDEAD_BEEF, "R4 word select", v, 32'hDEAD_BEEF);
    getWord(5, 0, 8, v);
    check(v === 32'h0123_4567, "R4 neighbour word", v, 32'h0123_4567);
  endtask

  task automatic tHitInv();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(10, 1, {20'hABCDE, 12'h07F});
    setTag(10, 0, {20'h33333, 12'h060});
    setWord(10, 1, 0, 32'h1111_2222);
    setWord(10, 1, 15, 32'h3333_4444);
    runCmd(5'h1A, hitAddr(20'hABCDE, 10, 6'h08), 0, s, a, d, c);
    check(!s, "R7 no wb", 32'(s), 32'd0);
    check(c == 2, "R2 cycles hit-inv", 32'(c), 32'd2);
    getTag(10, 1, v);
    check(v === {20'hABCDE, 12'h010}, "R7 tag cleared", v, {20'hABCDE, 12'h010});
    getTag(10, 0, v);
    check(v === {20'h33333, 12'h060}, "R6 other way untouched", v, {20'h33333, 12'h060});
    getWord(10, 1, 0, v);
    check(v === 32'd0, "R7 word0 zeroed", v, 32'd0);
    getWord(10, 1, 15, v);
    check(v === 32'd0, "R7 word15 zeroed", v, 32'd0);
  endtask

  task automatic tHitMiss();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(12, 0, {20'hABCDE, 12'h040});
    setTag(12, 1, {20'h44444, 12'h060});
    runCmd(5'h18, hitAddr(20'hABCDE, 12, 6'h00), 0, s, a, d, c);
    check(!s, "R6 miss no wb", 32'(s), 32'd0);
    check(c == 2, "R6 miss completes", 32'(c), 32'd2);
    getTag(12, 0, v);
    check(v === {20'hABCDE, 12'h040}, "R6 invalid way unchanged", v, {20'hABCDE, 12'h040});
    getTag(12, 1, v);
    check(v === {20'h44444, 12'h060}, "R6 way1 unchanged", v, {20'h44444, 12'h060});
  endtask

  task automatic tHitWb();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(7, 0, {20'h5A5A5, 12'h060});
    setTag(7, 1, {20'h5A5A5, 12'h070});
    setWord(7, 0, 0, 32'h1111_0000);
    setWord(7, 0, 15, 32'h2222_000F);
    runCmd(5'h1C, hitAddr(20'h5A5A5, 7, 6'h24), 3, s, a, d, c);
    check(s, "R9 wb issued", 32'(s), 32'd1);
    check(a === hitAddr(20'h5A5A5, 7, 6'h00), "R12 wb addr", a, hitAddr(20'h5A5A5, 7, 6'h00));
    check(d[31:0] === 32'h1111_0000, "R12 wb word0", d[31:0], 32'h1111_0000);
    check(d[511:480] === 32'h2222_000F, "R12 wb word15", d[511:480], 32'h2222_000F);
    check(c == 6, "R12 done after handshake", 32'(c), 32'd6);
    getTag(7, 0, v);
    check(v === {20'h5A5A5, 12'h020}, "R9 dirty only cleared, R6 way0 wins", v, {20'h5A5A5, 12'h020});
    getTag(7, 1, v);
    check(v === {20'h5A5A5, 12'h070}, "R6 way1 untouched", v, {20'h5A5A5, 12'h070});
  endtask

  task automatic tHitWbInv();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(20, 1, {20'hEEEEE, 12'h030});
    setWord(20, 1, 3, 32'hCAFE_0003);
    runCmd(5'h18, hitAddr(20'hEEEEE, 20, 6'h3C), 1, s, a, d, c);
    check(s, "R8 wb on clean valid line", 32'(s), 32'd1);
    check(a === hitAddr(20'hEEEEE, 20, 6'h00), "R8 wb addr", a, hitAddr(20'hEEEEE, 20, 6'h00));
    check(d[127:96] === 32'hCAFE_0003, "R8 wb word3", d[127:96], 32'hCAFE_0003);
    check(c == 4, "R12 cycles delay1", 32'(c), 32'd4);
    getTag(20, 1, v);
    check(v === {20'hEEEEE, 12'h010}, "R8 tag cleared", v, {20'hEEEEE, 12'h010});
  endtask

  task automatic tIdxInv();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(30, 1, {20'hABCDE, 12'h06F});
    runCmd(5'h16, idxAddr(30, 0, 1), 0, s, a, d, c);
    check(!s, "R10 no wb", 32'(s), 32'd0);
    getTag(30, 1, v);
    check(v === {20'hABCDE, 12'h000}, "R10 tag cleared", v, {20'hABCDE, 12'h000});
  endtask

  task automatic tIdxWbInv();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(40, 0, {20'hFFF00, 12'h040});
    runCmd(5'h14, {20'h11111, 6'd40, 6'h00}, 2, s, a, d, c);
    check(s, "R11 wb on dirty", 32'(s), 32'd1);
    check(a === {20'hFFF00, 6'd40, 6'h00}, "R11 wb uses tag page", a, {20'hFFF00, 6'd40, 6'h00});
    getTag(40, 0, v);
    check(v === {20'hFFF00, 12'h000}, "R11 tag cleared", v, {20'hFFF00, 12'h000});
    runCmd(5'h14, {20'h11111, 6'd40, 6'h00}, 0, s, a, d, c);
    check(!s, "R11 clean line no wb", 32'(s), 32'd0);
  endtask

  task automatic tUnknown();
    logic [31:0] v;
    bit s; logic [31:0] a; logic [511:0] d; int c;
    setTag(50, 1, {20'hABCDE, 12'h07F});
    diagWr(32'h0000_55AA);
    runCmd(5'h15, idxAddr(50, 0, 1), 0, s, a, d, c);
    check(!s && c == 2, "R13 completes no wb", 32'(c), 32'd2);
    runCmd(5'h1F, hitAddr(20'hABCDE, 50, 6'h01), 0, s, a, d, c);
    check(!s, "R13 no wb 1F", 32'(s), 32'd0);
    check(diagRdData === 32'h0000_55AA, "R13 diag kept", diagRdData, 32'h0000_55AA);
    getTag(50, 1, v);
    check(v === {20'hABCDE, 12'h07F}, "R13 tag kept", v, {20'hABCDE, 12'h07F});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDiagReg();
    tTagDiag();
    tDataDiag();
    tHitInv();
    tHitMiss();
    tHitWb();
    tHitWbInv();
    tIdxInv();
    tIdxWbInv();
    tUnknown();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule